// File: doc/BRIEF.md
# Eight-Input Vectored Priority Interrupt Controller

This block collects up to eight peripheral request lines, decides which of them a processor should service next, and hands that processor an 8-bit vector during a two-pulse acknowledge handshake. Requests are held in a pending register. A mask selects which inputs may compete. An in-service register records which interrupts the processor is currently handling, so that a new request is only raised to the processor when it outranks everything already in service.

Software controls the block through a two-address register port. A write to address 0 with bit 4 set is a setup word. It selects the trigger mode and the priority mode, empties the pending and in-service registers, and makes the next write to address 1 load the vector base. Any other write to address 0 is a run-time command: it can retire the current interrupt, switch between fixed and rotating priority, or both. Writes to address 1 outside the setup sequence load the mask, and reads of address 1 return it. The processor side consists of a request output `intr_o`, an acknowledge strobe, and a vector bus with an output enable. That enable stands in for a tri-state data bus.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the mask reads 8'hFF, `intr_o` is low, `vec_oe` is low on the next acknowledge pulse, and the block is in edge trigger mode with fixed priority and vector base 0.
- R2: In edge mode a 0-to-1 change on `irq_line[i]` sets pending bit i one clock later. The bit stays set after the line drops and is cleared only by the acknowledge that grants it, or by a setup word.
- R3: In level mode pending bit i follows `irq_line[i]` with a one-clock delay. A request whose line has fallen before the first acknowledge pulse is not granted.
- R4: Mask bit i = 1 keeps input i from raising `intr_o`. A pending edge request hidden by the mask raises `intr_o` once that mask bit is written to 0. Address 1 reads back the mask.
- R5: In fixed mode the lowest-numbered eligible input wins, with input 0 highest.
- R6: `intr_o` is high only when some unmasked request is pending and outranks the highest-priority in-service interrupt. An equal or lower request stays blocked, and a higher one raises `intr_o` while others are in service.
- R7: Acknowledge pulses alternate between first and second. A first pulse moves the winner from pending to in-service and leaves `vec_oe` low. A second pulse drives `vec_oe` high with the vector on `vec_data` during that pulse.
- R8: The vector is the programmed base plus the input number, modulo 256 (base 8, input 5 gives 13; base 8'hFC, input 6 gives 8'h02).
- R9: Writing 8'h20 to address 0 (bit 5 set, bit 4 clear) clears the highest-priority in-service bit, which unblocks lower requests.
- R10: In rotating mode, the input retired by an end-of-interrupt command becomes the lowest priority. The input numbered one above it becomes the highest.
- R11: A write to address 0 with bit 4 set selects level mode when bit 3 = 1 and rotating mode when bit 2 = 1. It clears pending and in-service state and resets the rotation. The next write to address 1 loads the vector base; later writes to address 1 load the mask.
- R12: A write to address 0 with bit 7 set and bit 4 clear selects rotating priority when bit 6 = 1 and fixed priority when bit 6 = 0. The change takes effect on the next decision.
- R13: If nothing is eligible at the first pulse, the second pulse drives base + 7 and the in-service register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address: 0 = command/setup, 1 = mask/base |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mask at address 1, zero otherwise |
| irq_line | input | 8 | Peripheral request lines, bit i = input i |
| intr_o | output | 1 | Interrupt request to the processor |
| ack_pulse | input | 1 | Acknowledge strobe, one cycle per pulse |
| vec_oe | output | 1 | High while the vector is driven (second pulse) |
| vec_data | output | 8 | Vector value, zero when not driven |

## Verification
A line change or a register write takes effect at the first rising edge after it is driven. The bench therefore drives every stimulus on a falling edge and samples `intr_o` and the read-back mask no earlier than the following falling edge. `vec_oe`, `vec_data` and `bus_rdata` are combinational from the strobe in the same cycle, so they are sampled 1 ns after the strobe rises and before the edge that consumes it. The level-mode drop test holds the line low for one full edge before the first pulse, so the pending bit has already fallen when the grant is decided.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    // decode positions inside a write to address 0
    localparam int CFG_BIT  = 4;  // setup word
    localparam int LVL_BIT  = 3;  // setup: level trigger
    localparam int ROT_BIT  = 2;  // setup: rotating priority
    localparam int EOI_BIT  = 5;  // command: retire current interrupt
    localparam int PSEL_BIT = 7;  // command: change priority mode
    localparam int PVAL_BIT = 6;  // command: 1 = rotating

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } ack_phase_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         level_mode,
    input  logic [N-1:0] clr,
    input  logic         flush,
    output logic [N-1:0] irr
);
    typedef struct packed {
        logic [N-1:0] irr;
        logic [N-1:0] prev;
    } lat_t;

    lat_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.prev = lines;
        if (level_mode) begin
            l_d.irr = lines;
        end else begin
            l_d.irr = (l_q.irr & ~clr) | (lines & ~l_q.prev);
        end
        if (flush) begin
            l_d.irr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign irr = l_q.irr;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [LW-1:0] start,
    output logic          any,
    output logic [LW-1:0] idx,
    output logic [LW-1:0] rank
);
    logic [LW-1:0] pos;

    always_comb begin
        any  = |req;
        idx  = start;
        rank = '0;
        pos  = start;
        for (int k = N - 1; k >= 0; k--) begin
            pos = start + LW'(k);
            if (req[pos]) begin
                idx  = pos;
                rank = LW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N_IRQ-1:0] irq_line,
    output logic          intr_o,
    input  logic          ack_pulse,
    output logic          vec_oe,
    output logic [DW-1:0] vec_data
);
    localparam int LW = $clog2(N_IRQ);

    typedef struct packed {
        logic [N_IRQ-1:0] mask;
        logic [N_IRQ-1:0] isr;
        logic [DW-1:0]    base;
        logic             base_next;
        logic             level;
        logic             rotate;
        logic [LW-1:0]    lowest;
        ack_phase_e       phase;
        logic [LW-1:0]    sel;
        logic             sel_ok;
    } st_t;

    st_t st_d, st_q;

    logic [N_IRQ-1:0] irr_q;
    logic [N_IRQ-1:0] clr_d;
    logic             flush_d;
    logic [N_IRQ-1:0] pend;
    logic [LW-1:0]    start;
    logic             p_any, s_any;
    logic [LW-1:0]    p_idx, s_idx, p_rank, s_rank;
    logic             grant_ok;
    logic             first_p, second_p;
    logic             wr_cmd, wr_dat;

    irq_req_latch #(.N(N_IRQ)) req_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (irq_line),
        .level_mode(st_q.level),
        .clr       (clr_d),
        .flush     (flush_d),
        .irr       (irr_q)
    );

    assign pend  = irr_q & ~st_q.mask;
    assign start = st_q.rotate ? LW'(st_q.lowest + LW'(1)) : '0;

    irq_prio_pick #(.N(N_IRQ), .LW(LW)) pend_pick_i (
        .req  (pend),
        .start(start),
        .any  (p_any),
        .idx  (p_idx),
        .rank (p_rank)
    );

    irq_prio_pick #(.N(N_IRQ), .LW(LW)) isr_pick_i (
        .req  (st_q.isr),
        .start(start),
        .any  (s_any),
        .idx  (s_idx),
        .rank (s_rank)
    );

    assign grant_ok = p_any && (!s_any || (p_rank < s_rank));
    assign first_p  = ack_pulse && (st_q.phase == PH_FIRST);
    assign second_p = ack_pulse && (st_q.phase == PH_SECOND);
    assign wr_cmd   = bus_wr && !bus_addr;
    assign wr_dat   = bus_wr && bus_addr;

    always_comb begin
        st_d    = st_q;
        clr_d   = '0;
        flush_d = 1'b0;

        // acknowledge handshake
        if (first_p) begin
            st_d.phase  = PH_SECOND;
            st_d.sel    = p_idx;
            st_d.sel_ok = grant_ok;
            if (grant_ok) begin
                st_d.isr[p_idx] = 1'b1;
                clr_d[p_idx]    = 1'b1;
            end
        end
        if (second_p) begin
            st_d.phase = PH_FIRST;
        end

        // command / setup port
        if (wr_cmd) begin
            if (bus_wdata[CFG_BIT]) begin
                st_d.level     = bus_wdata[LVL_BIT];
                st_d.rotate    = bus_wdata[ROT_BIT];
                st_d.lowest    = '1;
                st_d.isr       = '0;
                st_d.base_next = 1'b1;
                flush_d        = 1'b1;
            end else begin
                if (bus_wdata[EOI_BIT] && s_any) begin
                    st_d.isr[s_idx] = 1'b0;
                    if (st_q.rotate) begin
                        st_d.lowest = s_idx;
                    end
                end
                if (bus_wdata[PSEL_BIT]) begin
                    st_d.rotate = bus_wdata[PVAL_BIT];
                end
            end
        end

        // mask / base port
        if (wr_dat) begin
            if (st_q.base_next) begin
                st_d.base      = bus_wdata;
                st_d.base_next = 1'b0;
            end else begin
                st_d.mask = bus_wdata[N_IRQ-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask      <= '1;
            st_q.isr       <= '0;
            st_q.base      <= '0;
            st_q.base_next <= 1'b0;
            st_q.level     <= 1'b0;
            st_q.rotate    <= 1'b0;
            st_q.lowest    <= '1;
            st_q.phase     <= PH_FIRST;
            st_q.sel       <= '0;
            st_q.sel_ok    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign intr_o    = grant_ok;
    assign vec_oe    = second_p;
    assign vec_data  = second_p ?
                       DW'(st_q.base + DW'(st_q.sel_ok ? st_q.sel : LW'(N_IRQ - 1))) : '0;
    assign bus_rdata = (bus_rd && bus_addr) ? DW'(st_q.mask) : '0;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          ack_pulse,
    input logic          intr_o,
    input logic          vec_oe,
    input logic [N-1:0]  irr,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  isr
);
    logic odd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else if (ack_pulse) begin
            odd_q <= !odd_q;
        end
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !intr_o); // R4

    AST_INTR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> ((irr & ~mask) != '0)); // R6

    AST_VEC_SECOND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (ack_pulse && odd_q)); // R7

    AST_FIRST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && !odd_q) |-> !vec_oe); // R7

    AST_GRANT_ADDS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && !odd_q && intr_o && !bus_wr)
        |=> ($countones(isr) == $past($countones(isr)) + 1)); // R6

    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata == 8'h20 && isr != '0 && !ack_pulse)
        |=> ($countones(isr) + 1 == $past($countones(isr)))); // R9

    AST_ISR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_pulse && !bus_wr) |=> $stable(isr)); // R13
endmodule

bind irq_vec_ctrl irq_vec_chk #(.N(N_IRQ), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ack_pulse(ack_pulse),
    .intr_o   (intr_o),
    .vec_oe   (vec_oe),
    .irr      (irr_q),
    .mask     (st_q.mask),
    .isr      (st_q.isr)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
    localparam int NROWS = 97;
    // row = {req, op, arg, expected}
    localparam logic [7:0] OP_WR0 = 8'd0, OP_WR1 = 8'd1, OP_LIN = 8'd2, OP_RDM = 8'd3,
                           OP_INT = 8'd4, OP_AK1 = 8'd5, OP_AK2 = 8'd6;

    localparam logic [31:0] TBL [NROWS] = '{
        32'h01_03_00_FF, 32'h01_04_00_00,                                   // R1 reset state
        32'h0B_00_10_00, 32'h0B_01_08_00, 32'h0B_01_00_00, 32'h0B_03_00_00, // R11 setup, base 8, mask 0
        32'h02_02_20_00, 32'h02_02_00_00, 32'h02_04_00_01,                  // R2 IR5 edge held
        32'h07_05_00_00, 32'h08_06_00_0D,                                   // R7 R8 vector 13
        32'h06_04_00_00, 32'h06_02_08_00, 32'h06_02_00_00, 32'h06_04_00_01, // R6 IR3 preempts
        32'h07_05_00_00, 32'h07_06_00_0B,
        32'h06_02_80_00, 32'h06_02_00_00, 32'h06_04_00_00,                  // R6 IR7 blocked
        32'h09_00_20_00, 32'h09_04_00_00, 32'h09_00_20_00, 32'h09_04_00_01, // R9 two EOIs
        32'h08_05_00_00, 32'h08_06_00_0F, 32'h09_00_20_00,
        32'h04_01_04_00, 32'h04_02_04_00, 32'h04_02_00_00, 32'h04_04_00_00, // R4 masked IR2
        32'h04_03_00_04, 32'h04_01_00_00, 32'h04_04_00_01,
        32'h04_05_00_00, 32'h04_06_00_0A, 32'h09_00_20_00,
        32'h05_02_42_00, 32'h05_02_00_00, 32'h05_05_00_00, 32'h05_06_00_09, // R5 fixed order
        32'h05_00_20_00, 32'h05_05_00_00, 32'h05_06_00_0E, 32'h05_00_20_00,
        32'h05_04_00_00,
        32'h0C_00_C0_00,                                                    // R12 rotate on
        32'h0A_02_03_00, 32'h0A_02_00_00, 32'h0A_05_00_00, 32'h0A_06_00_08, // R10 rotation
        32'h0A_00_20_00, 32'h0A_02_01_00, 32'h0A_02_00_00, 32'h0A_05_00_00,
        32'h0A_06_00_09, 32'h0A_00_20_00, 32'h0A_05_00_00, 32'h0A_06_00_08,
        32'h0A_00_20_00,
        32'h0C_00_80_00, 32'h0C_02_03_00, 32'h0C_02_00_00, 32'h0C_05_00_00, // R12 back to fixed
        32'h0C_06_00_08, 32'h0C_00_20_00, 32'h0C_05_00_00, 32'h0C_06_00_09,
        32'h0C_00_20_00,
        32'h08_00_10_00, 32'h08_01_FC_00, 32'h08_01_00_00, 32'h08_02_40_00, // R8 wrap
        32'h08_02_00_00, 32'h08_05_00_00, 32'h08_06_00_02, 32'h08_00_20_00,
        32'h03_00_18_00, 32'h03_01_20_00, 32'h03_01_00_00, 32'h03_02_10_00, // R3 level mode
        32'h03_04_00_01, 32'h03_05_00_00, 32'h03_06_00_24, 32'h03_00_20_00,
        32'h03_04_00_01, 32'h03_02_00_00, 32'h03_04_00_00, 32'h03_02_02_00,
        32'h03_04_00_01, 32'h03_02_00_00,
        32'h0D_05_00_00, 32'h0D_06_00_27, 32'h0D_04_00_00, 32'h0D_02_80_00, // R13 spurious
        32'h0D_04_00_01, 32'h0D_02_00_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_line = '0;
    logic       intr_o;
    logic       ack_pulse = 1'b0;
    logic       vec_oe;
    logic [7:0] vec_data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_vec_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_line (irq_line),
        .intr_o   (intr_o),
        .ack_pulse(ack_pulse),
        .vec_oe   (vec_oe),
        .vec_data (vec_data)
    );

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_row(input logic [31:0] row);
        int         req;
        logic [7:0] op, arg, exp;
        req = int'(row[31:24]);
        op  = row[23:16];
        arg = row[15:8];
        exp = row[7:0];
        @(negedge clk);
        case (op)
            OP_WR0, OP_WR1: begin
                bus_wr = 1'b1; bus_addr = (op == OP_WR1); bus_wdata = arg;
                @(negedge clk);
                bus_wr = 1'b0;
            end
            OP_LIN: begin
                irq_line = arg;
                @(negedge clk);
            end
            OP_RDM: begin
                bus_rd = 1'b1; bus_addr = 1'b1;
                #1 chk(req, "mask readback", bus_rdata, exp);
                bus_rd = 1'b0;
            end
            OP_INT: begin
                chk(req, "intr_o", {7'b0, intr_o}, exp);
            end
            OP_AK1: begin
                ack_pulse = 1'b1;
                #1 chk(req, "vec_oe on first pulse", {7'b0, vec_oe}, 8'h00);
                @(negedge clk);
                ack_pulse = 1'b0;
            end
            OP_AK2: begin
                ack_pulse = 1'b1;
                #1;
                chk(req, "vec_oe on second pulse", {7'b0, vec_oe}, 8'h01);
                chk(req, "vector", vec_data, exp);
                @(negedge clk);
                ack_pulse = 1'b0;
            end
            default: ;
        endcase
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NROWS; i++) begin
            run_row(TBL[i]);
        end

        // directed: reset in the middle of activity (R1)
        @(negedge clk);
        irq_line = 8'h01;
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        irq_line = 8'h00;
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "intr_o after reset", {7'b0, intr_o}, 8'h00);
        run_row(32'h01_03_00_FF); // R1 mask back to all ones
        @(negedge clk);
        ack_pulse = 1'b1;
        #1 chk(1, "vec_oe first pulse after reset", {7'b0, vec_oe}, 8'h00);
        @(negedge clk);
        ack_pulse = 1'b1;
        #1 chk(1, "spurious vector uses base 0", vec_data, 8'h07);
        @(negedge clk);
        ack_pulse = 1'b0;

        // directed: edge request under a reset-state mask, then unmask (R2, R4)
        run_row(32'h02_02_10_00);
        run_row(32'h02_02_00_00);
        run_row(32'h04_04_00_00);
        run_row(32'h04_01_00_00);
        run_row(32'h02_04_00_01);
        run_row(32'h02_05_00_00);
        run_row(32'h08_06_00_04); // R8 base 0 + input 4

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule